// File: doc/BRIEF.md
# Workspace Context Switcher

This block keeps the only three hard registers of a processor whose general registers live in memory: the workspace pointer, the program counter and the status word. Register n of the current set is the memory word at byte address WP + 2n, so writing a new WP moves the whole register set at once. The block never holds general registers in flops. It fetches and stores them through a word-wide request/acknowledge memory port.

Decode logic outside the block sends it one-cycle command pulses. A vectored switch reads a new WP and a new PC from two consecutive words. It then parks the old WP, PC and ST in registers 13, 14 and 15 of the new set. The trap form of the switch finds its vector in a fixed table, one entry per device number. After the park it also stores the operand's effective address in register 11 of the new set. A device that has its own hardware bypasses the trap entirely. A return command pulls WP, PC and ST back out of registers 13 to 15. Two single-word commands load WP from an immediate and store WP into a register.

The new WP, PC and ST become visible only when the whole sequence has finished. Outside a sequence, the surrounding pipeline can overwrite PC and ST directly.

Top module: `ctxsw_top`

## Requirements
- R1: After reset, wp, pc and st read 0, busy and done are low, and mem_req is low.
- R2: For cmd_op 0 (vectored switch) with operand address A, the block makes these accesses in this order: read A, read A+2, write old WP to newWP+26, write old PC to newWP+28, write old ST to newWP+30. After that, wp and pc hold the two words read, and st is unchanged.
- R3: For cmd_op 1 (trap) on device n, when xop_hw_mask bit n is 0, the vector address is XOP_BASE + 4n. The accesses are the same five as in R2, followed by a write of cmd_addr to newWP+22.
- R4: For cmd_op 1 on device n, when xop_hw_mask bit n is 1, no memory access happens, done pulses in the cycle after acceptance, and wp, pc and st keep their values.
- R5: For cmd_op 2 (return), the block reads WP+26, WP+28 and WP+30 in that order. It then loads wp, pc and st from those three words respectively.
- R6: For cmd_op 3 (load WP), wp takes cmd_imm in the cycle after acceptance, done pulses in that same cycle, and no memory access happens.
- R7: For cmd_op 4 (store WP), the block makes a single write of the current WP to WP + 2*cmd_reg.
- R8: Bit 0 of every WP and PC value loaded is forced to 0, and every memory address the block drives is even.
- R9: While mem_req is high without mem_ack, mem_req, mem_addr, mem_we and mem_wdata hold steady. Every access waits for its acknowledge.
- R10: done is a single-cycle pulse that comes one cycle after the last acknowledge of a command. busy is high from the cycle after acceptance through the done cycle.
- R11: A command that arrives while busy is high is ignored. wp, pc and st stay unchanged until the sequence commits.
- R12: While the block is idle, pc_wr and st_wr load pc (bit 0 cleared) and st, visible in the next cycle. While busy is high, both are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle command pulse |
| cmd_op | input | 3 | Command code (0 switch, 1 trap, 2 return, 3 load WP, 4 store WP) |
| cmd_addr | input | W | Operand address or effective address |
| cmd_imm | input | W | Immediate for load WP |
| cmd_dev | input | log2(NDEV) | Trap device number |
| cmd_reg | input | log2(NREG) | Target register for store WP |
| xop_hw_mask | input | NDEV | Bit n set: device n is served in hardware |
| pc_wr | input | 1 | Write PC from the pipeline |
| pc_wdata | input | W | New PC value |
| st_wr | input | 1 | Write ST from the pipeline |
| st_wdata | input | W | New ST value |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | W | Byte address of the word |
| mem_wdata | output | W | Write data |
| mem_rdata | input | W | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access complete |
| wp | output | W | Workspace pointer |
| pc | output | W | Program counter |
| st | output | W | Status word |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Command finished |

## Verification
The bench builds the block with its default parameters: 16-bit words, sixteen trap devices, sixteen workspace registers and a vector table at 0x0040. At these values, device 15 reaches the highest vector slot (0x007C), and odd vector contents exercise the bit-0 clearing. The memory model acknowledges after a rotating 0 to 3 cycle delay. This covers both back-to-back acknowledges and long holds of a request. A second command and a PC write are injected in the middle of a switch to confirm they are dropped.

// File: rtl/ctxsw_pkg.sv
`timescale 1ns/1ps
package ctxsw_pkg;

  typedef enum logic [2:0] {
    CMD_VSWITCH = 3'd0,
    CMD_TRAP    = 3'd1,
    CMD_RETURN  = 3'd2,
    CMD_LOADWP  = 3'd3,
    CMD_STOREWP = 3'd4
  } cmd_e;

  typedef enum logic [3:0] {
    SQ_IDLE,
    SQ_RD_NWP,
    SQ_RD_NPC,
    SQ_WR_SWP,
    SQ_WR_SPC,
    SQ_WR_SST,
    SQ_WR_EA,
    SQ_RD_SWP,
    SQ_RD_SPC,
    SQ_RD_SST,
    SQ_WR_WP,
    SQ_DONE
  } seq_e;

  // Workspace slots used by the switch and return sequences
  localparam int unsigned SLOT_EA  = 11;
  localparam int unsigned SLOT_SWP = 13;
  localparam int unsigned SLOT_SPC = 14;
  localparam int unsigned SLOT_SST = 15;

endpackage

// File: rtl/ctxsw_seq.sv
`timescale 1ns/1ps
module ctxsw_seq
  import ctxsw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_op,
  input  logic       trap_served,
  input  logic       mem_ack,
  output seq_e       state,
  output logic       accept,
  output logic       mem_req,
  output logic       commit_switch,
  output logic       commit_return,
  output logic       busy,
  output logic       done
);

  seq_e state_q, state_d;
  logic is_trap_q, is_trap_d;

  always_comb begin
    state_d   = state_q;
    is_trap_d = is_trap_q;
    accept    = cmd_valid && (state_q == SQ_IDLE);
    case (state_q)
      SQ_IDLE: begin
        if (accept) begin
          is_trap_d = (cmd_op == CMD_TRAP);
          case (cmd_op)
            CMD_VSWITCH: state_d = SQ_RD_NWP;
            CMD_TRAP:    state_d = trap_served ? SQ_DONE : SQ_RD_NWP;
            CMD_RETURN:  state_d = SQ_RD_SWP;
            CMD_LOADWP:  state_d = SQ_DONE;
            CMD_STOREWP: state_d = SQ_WR_WP;
            default:     state_d = SQ_IDLE;
          endcase
        end
      end
      SQ_RD_NWP: if (mem_ack) state_d = SQ_RD_NPC;
      SQ_RD_NPC: if (mem_ack) state_d = SQ_WR_SWP;
      SQ_WR_SWP: if (mem_ack) state_d = SQ_WR_SPC;
      SQ_WR_SPC: if (mem_ack) state_d = SQ_WR_SST;
      SQ_WR_SST: if (mem_ack) state_d = is_trap_q ? SQ_WR_EA : SQ_DONE;
      SQ_WR_EA:  if (mem_ack) state_d = SQ_DONE;
      SQ_RD_SWP: if (mem_ack) state_d = SQ_RD_SPC;
      SQ_RD_SPC: if (mem_ack) state_d = SQ_RD_SST;
      SQ_RD_SST: if (mem_ack) state_d = SQ_DONE;
      SQ_WR_WP:  if (mem_ack) state_d = SQ_DONE;
      SQ_DONE:   state_d = SQ_IDLE;
      default:   state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SQ_IDLE;
      is_trap_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) is_trap_q <= is_trap_d;
    end
  end

  always_comb begin
    mem_req = (state_q != SQ_IDLE) && (state_q != SQ_DONE);
    commit_switch = mem_ack && (((state_q == SQ_WR_SST) && !is_trap_q) ||
                                (state_q == SQ_WR_EA));
    commit_return = mem_ack && (state_q == SQ_RD_SST);
    busy  = (state_q != SQ_IDLE);
    done  = (state_q == SQ_DONE);
    state = state_q;
  end

endmodule

// File: rtl/ctxsw_ctx.sv
`timescale 1ns/1ps
module ctxsw_ctx
  import ctxsw_pkg::*;
#(
  parameter int unsigned W        = 16,
  parameter int unsigned DEVW     = 4,
  parameter int unsigned RIDXW    = 4,
  parameter int unsigned XOP_BASE = 'h40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  seq_e             state,
  input  logic             accept,
  input  logic [2:0]       cmd_op,
  input  logic [W-1:0]     cmd_addr,
  input  logic [W-1:0]     cmd_imm,
  input  logic [DEVW-1:0]  cmd_dev,
  input  logic [RIDXW-1:0] cmd_reg,
  input  logic             pc_wr,
  input  logic [W-1:0]     pc_wdata,
  input  logic             st_wr,
  input  logic [W-1:0]     st_wdata,
  input  logic             mem_ack,
  input  logic [W-1:0]     mem_rdata,
  input  logic             commit_switch,
  input  logic             commit_return,
  output logic [W-1:0]     wp,
  output logic [W-1:0]     pc,
  output logic [W-1:0]     st,
  output logic [W-1:0]     tmp_wp,
  output logic [W-1:0]     vec,
  output logic [W-1:0]     ea,
  output logic [RIDXW-1:0] reg_idx
);

  localparam logic [W-1:0] EVEN  = ~W'(1);
  localparam logic [W-1:0] TBASE = W'(XOP_BASE);

  logic [W-1:0] wp_q, pc_q, st_q, twp_q, tpc_q, vec_q, ea_q;
  logic [RIDXW-1:0] ridx_q;

  logic         idle, commit;
  logic         wp_en, pc_en, st_en, twp_en, tpc_en;
  logic [W-1:0] wp_d, pc_d, st_d, vec_d;

  always_comb begin
    idle   = (state == SQ_IDLE);
    commit = commit_switch || commit_return;
    wp_en  = (accept && (cmd_op == CMD_LOADWP)) || commit;
    wp_d   = commit ? twp_q : (cmd_imm & EVEN);
    pc_en  = (idle && pc_wr) || commit;
    pc_d   = commit ? tpc_q : (pc_wdata & EVEN);
    st_en  = (idle && st_wr) || commit_return;
    st_d   = commit_return ? mem_rdata : st_wdata;
    twp_en = mem_ack && ((state == SQ_RD_NWP) || (state == SQ_RD_SWP));
    tpc_en = mem_ack && ((state == SQ_RD_NPC) || (state == SQ_RD_SPC));
    vec_d  = (cmd_op == CMD_TRAP) ? ((TBASE + (W'(cmd_dev) << 2)) & EVEN)
                                  : (cmd_addr & EVEN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      pc_q   <= '0;
      st_q   <= '0;
      twp_q  <= '0;
      tpc_q  <= '0;
      vec_q  <= '0;
      ea_q   <= '0;
      ridx_q <= '0;
    end else begin
      if (wp_en)  wp_q  <= wp_d;
      if (pc_en)  pc_q  <= pc_d;
      if (st_en)  st_q  <= st_d;
      if (twp_en) twp_q <= mem_rdata & EVEN;
      if (tpc_en) tpc_q <= mem_rdata & EVEN;
      if (accept) begin
        vec_q  <= vec_d;
        ea_q   <= cmd_addr;
        ridx_q <= cmd_reg;
      end
    end
  end

  assign wp      = wp_q;
  assign pc      = pc_q;
  assign st      = st_q;
  assign tmp_wp  = twp_q;
  assign vec     = vec_q;
  assign ea      = ea_q;
  assign reg_idx = ridx_q;

endmodule

// File: rtl/ctxsw_port.sv
`timescale 1ns/1ps
module ctxsw_port
  import ctxsw_pkg::*;
#(
  parameter int unsigned W     = 16,
  parameter int unsigned RIDXW = 4
) (
  input  seq_e             state,
  input  logic [W-1:0]     wp,
  input  logic [W-1:0]     pc,
  input  logic [W-1:0]     st,
  input  logic [W-1:0]     tmp_wp,
  input  logic [W-1:0]     vec,
  input  logic [W-1:0]     ea,
  input  logic [RIDXW-1:0] reg_idx,
  output logic [W-1:0]     mem_addr,
  output logic             mem_we,
  output logic [W-1:0]     mem_wdata
);

  function automatic logic [W-1:0] slot(input logic [W-1:0] base,
                                        input logic [RIDXW-1:0] idx);
    return base + (W'(idx) << 1);
  endfunction

  always_comb begin
    mem_addr  = '0;
    mem_we    = 1'b0;
    mem_wdata = '0;
    case (state)
      SQ_RD_NWP: mem_addr = vec;
      SQ_RD_NPC: mem_addr = vec + W'(2);
      SQ_WR_SWP: begin
        mem_addr = slot(tmp_wp, RIDXW'(SLOT_SWP)); mem_we = 1'b1; mem_wdata = wp;
      end
      SQ_WR_SPC: begin
        mem_addr = slot(tmp_wp, RIDXW'(SLOT_SPC)); mem_we = 1'b1; mem_wdata = pc;
      end
      SQ_WR_SST: begin
        mem_addr = slot(tmp_wp, RIDXW'(SLOT_SST)); mem_we = 1'b1; mem_wdata = st;
      end
      SQ_WR_EA: begin
        mem_addr = slot(tmp_wp, RIDXW'(SLOT_EA)); mem_we = 1'b1; mem_wdata = ea;
      end
      SQ_RD_SWP: mem_addr = slot(wp, RIDXW'(SLOT_SWP));
      SQ_RD_SPC: mem_addr = slot(wp, RIDXW'(SLOT_SPC));
      SQ_RD_SST: mem_addr = slot(wp, RIDXW'(SLOT_SST));
      SQ_WR_WP: begin
        mem_addr = slot(wp, reg_idx); mem_we = 1'b1; mem_wdata = wp;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ctxsw_top.sv
`timescale 1ns/1ps
module ctxsw_top
  import ctxsw_pkg::*;
#(
  parameter int unsigned W        = 16,
  parameter int unsigned NDEV     = 16,
  parameter int unsigned NREG     = 16,
  parameter int unsigned XOP_BASE = 'h40,
  localparam int unsigned DEVW    = $clog2(NDEV),
  localparam int unsigned RIDXW   = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [W-1:0]     cmd_addr,
  input  logic [W-1:0]     cmd_imm,
  input  logic [DEVW-1:0]  cmd_dev,
  input  logic [RIDXW-1:0] cmd_reg,
  input  logic [NDEV-1:0]  xop_hw_mask,
  input  logic             pc_wr,
  input  logic [W-1:0]     pc_wdata,
  input  logic             st_wr,
  input  logic [W-1:0]     st_wdata,
  output logic             mem_req,
  output logic             mem_we,
  output logic [W-1:0]     mem_addr,
  output logic [W-1:0]     mem_wdata,
  input  logic [W-1:0]     mem_rdata,
  input  logic             mem_ack,
  output logic [W-1:0]     wp,
  output logic [W-1:0]     pc,
  output logic [W-1:0]     st,
  output logic             busy,
  output logic             done
);

  // Reset asserts at once and releases on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  seq_e             seq_state;
  logic             accept, commit_switch, commit_return, trap_served;
  logic [W-1:0]     tmp_wp, vec, ea;
  logic [RIDXW-1:0] reg_idx;

  assign trap_served = xop_hw_mask[cmd_dev];

  ctxsw_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_core_n),
    .cmd_valid     (cmd_valid),
    .cmd_op        (cmd_op),
    .trap_served   (trap_served),
    .mem_ack       (mem_ack),
    .state         (seq_state),
    .accept        (accept),
    .mem_req       (mem_req),
    .commit_switch (commit_switch),
    .commit_return (commit_return),
    .busy          (busy),
    .done          (done)
  );

  ctxsw_ctx #(.W(W), .DEVW(DEVW), .RIDXW(RIDXW), .XOP_BASE(XOP_BASE)) u_ctx (
    .clk           (clk),
    .rst_n         (rst_core_n),
    .state         (seq_state),
    .accept        (accept),
    .cmd_op        (cmd_op),
    .cmd_addr      (cmd_addr),
    .cmd_imm       (cmd_imm),
    .cmd_dev       (cmd_dev),
    .cmd_reg       (cmd_reg),
    .pc_wr         (pc_wr),
    .pc_wdata      (pc_wdata),
    .st_wr         (st_wr),
    .st_wdata      (st_wdata),
    .mem_ack       (mem_ack),
    .mem_rdata     (mem_rdata),
    .commit_switch (commit_switch),
    .commit_return (commit_return),
    .wp            (wp),
    .pc            (pc),
    .st            (st),
    .tmp_wp        (tmp_wp),
    .vec           (vec),
    .ea            (ea),
    .reg_idx       (reg_idx)
  );

  ctxsw_port #(.W(W), .RIDXW(RIDXW)) u_port (
    .state     (seq_state),
    .wp        (wp),
    .pc        (pc),
    .st        (st),
    .tmp_wp    (tmp_wp),
    .vec       (vec),
    .ea        (ea),
    .reg_idx   (reg_idx),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata)
  );

endmodule

// File: rtl/ctxsw_chk.sv
`timescale 1ns/1ps
module ctxsw_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         mem_req,
  input logic         mem_we,
  input logic [W-1:0] mem_addr,
  input logic [W-1:0] mem_wdata,
  input logic         mem_ack,
  input logic [W-1:0] wp,
  input logic [W-1:0] pc,
  input logic [W-1:0] st,
  input logic         busy,
  input logic         done
);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !done));

  a_r8_even_addr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !mem_addr[0]);

  a_r8_even_ptrs: assert property (@(posedge clk) disable iff (!rst_n)
    !wp[0] && !pc[0]);

  a_r9_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                               $stable(mem_we) && $stable(mem_wdata)));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  a_r11_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(mem_req && mem_ack)) |=> ($stable(wp) && $stable(pc) && $stable(st)));

endmodule

bind ctxsw_top ctxsw_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ack   (mem_ack),
  .wp        (wp),
  .pc        (pc),
  .st        (st),
  .busy      (busy),
  .done      (done)
);

// File: tb/ctxsw_top_tb.sv
`timescale 1ns/1ps
module ctxsw_top_tb;

  localparam logic [15:0] EVEN = 16'hFFFE;
  localparam logic [15:0] TBASE = 16'h0040;

  typedef struct {
    logic [15:0] a;
    logic        we;
    logic [15:0] d;
  } acc_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [15:0] cmd_addr = '0, cmd_imm = '0;
  logic [3:0]  cmd_dev = '0, cmd_reg = '0;
  logic [15:0] xop_hw_mask = 16'h0020;
  logic        pc_wr = 1'b0, st_wr = 1'b0;
  logic [15:0] pc_wdata = '0, st_wdata = '0;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr, mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;
  logic [15:0] wp, pc, st;
  logic        busy, done;

  always #4ns clk = ~clk;

  ctxsw_top u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_imm(cmd_imm), .cmd_dev(cmd_dev), .cmd_reg(cmd_reg),
    .xop_hw_mask(xop_hw_mask), .pc_wr(pc_wr), .pc_wdata(pc_wdata),
    .st_wr(st_wr), .st_wdata(st_wdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .wp(wp), .pc(pc), .st(st), .busy(busy), .done(done)
  );

  // Reference state
  logic [15:0] mem [int];
  acc_t        exp_q [$];
  logic [15:0] m_wp = '0, m_pc = '0, m_st = '0;
  logic [15:0] pend_wp, pend_pc, pend_st, pend_pcw, pend_stw;
  bit          pend_sw_v = 0, pend_pcw_v = 0, pend_stw_v = 0;
  bit          arm_done = 0, busy_exp = 0, mon_en = 0;
  string       cur_tag = "R1";
  int          total = 0, fails = 0;
  int          lat_idx = 0, cnt = 0;
  bit          pend_acc = 0;
  logic [15:0] first_addr;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] rd(input logic [15:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return 16'h0000;
  endfunction

  function automatic void push(input logic [15:0] a, input logic we, input logic [15:0] d);
    acc_t e;
    e.a = a; e.we = we; e.d = d;
    exp_q.push_back(e);
  endfunction

  function automatic int next_lat();
    int t[4] = '{1, 0, 3, 2};
    lat_idx = (lat_idx + 1) % 4;
    return t[lat_idx];
  endfunction

  // Memory responder: acknowledges after a rotating delay, checks each access
  always @(negedge clk) begin
    if (mon_en) begin
      if (mem_ack) begin
        mem_ack = 1'b0;
        pend_acc = 0;
      end else if (mem_req) begin
        if (!pend_acc) begin
          pend_acc = 1;
          cnt = next_lat();
          first_addr = mem_addr;
        end
        if (cnt == 0) begin
          chk(mem_addr === first_addr, "R9", "address held until ack", mem_addr, first_addr);
          if (exp_q.size() == 0) begin
            chk(0, cur_tag, "unexpected access", mem_addr, 16'hxxxx);
          end else begin
            acc_t e;
            e = exp_q.pop_front();
            chk(mem_addr === e.a, cur_tag, "access address", mem_addr, e.a);
            chk(mem_we === e.we, cur_tag, "access direction", {15'd0, mem_we}, {15'd0, e.we});
            if (e.we) chk(mem_wdata === e.d, cur_tag, "write data", mem_wdata, e.d);
            if (exp_q.size() == 0) arm_done = 1;
          end
          if (mem_we) mem[int'(mem_addr)] = mem_wdata;
          else mem_rdata = rd(mem_addr);
          mem_ack = 1'b1;
        end else begin
          cnt--;
        end
      end
    end
  end

  // Per-cycle comparison against the reference state
  always @(posedge clk) begin
    #2ns;
    if (mon_en) begin
      if (arm_done && pend_sw_v) begin
        m_wp = pend_wp; m_pc = pend_pc; m_st = pend_st; pend_sw_v = 0;
      end
      if (pend_pcw_v) begin m_pc = pend_pcw; pend_pcw_v = 0; end
      if (pend_stw_v) begin m_st = pend_stw; pend_stw_v = 0; end
      chk(done === arm_done, "R10", "done", {15'd0, done}, {15'd0, arm_done});
      chk(busy === busy_exp, "R10", "busy", {15'd0, busy}, {15'd0, busy_exp});
      chk(wp === m_wp, cur_tag, "wp", wp, m_wp);
      chk(pc === m_pc, cur_tag, "pc", pc, m_pc);
      chk(st === m_st, cur_tag, "st", st, m_st);
      if (mem_req && exp_q.size() == 0)
        chk(0, cur_tag, "request with none expected", mem_addr, 16'hxxxx);
      if (arm_done) begin arm_done = 0; busy_exp = 0; end
    end
  end

  task automatic do_cmd(input logic [2:0] op, input logic [15:0] a, input logic [3:0] dev,
                        input logic [3:0] r, input logic [15:0] imm, input string tag);
    logic [15:0] v, nwp, npc;
    @(negedge clk);
    cur_tag = tag;
    pend_wp = m_wp; pend_pc = m_pc; pend_st = m_st;
    case (op)
      3'd0, 3'd1: begin
        v = (op == 3'd1) ? (TBASE + 16'(dev) * 16'd4) : (a & EVEN);
        if (op == 3'd1 && xop_hw_mask[dev]) begin
          arm_done = 1;
        end else begin
          nwp = rd(v) & EVEN;
          npc = rd(v + 16'd2) & EVEN;
          push(v, 0, 0);
          push(v + 16'd2, 0, 0);
          push(nwp + 16'd26, 1, m_wp);
          push(nwp + 16'd28, 1, m_pc);
          push(nwp + 16'd30, 1, m_st);
          if (op == 3'd1) push(nwp + 16'd22, 1, a);
          pend_wp = nwp; pend_pc = npc;
        end
      end
      3'd2: begin
        push(m_wp + 16'd26, 0, 0);
        push(m_wp + 16'd28, 0, 0);
        push(m_wp + 16'd30, 0, 0);
        pend_wp = rd(m_wp + 16'd26) & EVEN;
        pend_pc = rd(m_wp + 16'd28) & EVEN;
        pend_st = rd(m_wp + 16'd30);
      end
      3'd3: begin
        pend_wp = imm & EVEN;
        arm_done = 1;
      end
      default: begin
        push(m_wp + {11'd0, r, 1'b0}, 1, m_wp);
      end
    endcase
    pend_sw_v = 1;
    busy_exp = 1;
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_dev = dev; cmd_reg = r; cmd_imm = imm;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy_exp) begin
      @(negedge clk);
      n++;
      if (n > 300) begin
        chk(0, cur_tag, "command never finished", 16'd0, 16'd1);
        busy_exp = 0;
      end
    end
    @(negedge clk);
  endtask

  task automatic write_pc_st(input logic [15:0] p, input logic [15:0] s);
    @(negedge clk);
    cur_tag = "R12";
    pc_wr = 1'b1; pc_wdata = p; st_wr = 1'b1; st_wdata = s;
    pend_pcw = p & EVEN; pend_pcw_v = 1;
    pend_stw = s; pend_stw_v = 1;
    @(negedge clk);
    pc_wr = 1'b0; st_wr = 1'b0;
  endtask

  initial begin
    #(8ns * 150000);
    chk(0, "R10", "watchdog expired", 16'd0, 16'd1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    // Vector contents; odd words exercise bit-0 clearing (R8)
    mem[int'(16'h0200)] = 16'h0301;
    mem[int'(16'h0202)] = 16'h0455;
    mem[int'(16'h004C)] = 16'h0500;   // device 3 slot
    mem[int'(16'h004E)] = 16'h0600;
    mem[int'(16'h007C)] = 16'h0701;   // device 15 slot
    mem[int'(16'h007E)] = 16'h0802;
    mem[int'(16'h0210)] = 16'h0900;
    mem[int'(16'h0212)] = 16'h0A10;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state before the first command
    chk(busy === 1'b0 && mem_req === 1'b0 && done === 1'b0, "R1", "idle after reset",
        {13'd0, busy, mem_req, done}, 16'd0);
    chk(wp === 16'd0 && pc === 16'd0 && st === 16'd0, "R1", "registers after reset", wp | pc | st, 16'd0);
    mon_en = 1;

    write_pc_st(16'h0101, 16'h1234);           // R12
    repeat (2) @(negedge clk);

    do_cmd(3'd0, 16'h0200, 4'd0, 4'd0, 16'd0, "R2");  // R2 and R8
    wait_idle();
    cur_tag = "R8";
    chk(wp === 16'h0300 && pc === 16'h0454, "R8", "aligned switch target", wp ^ pc, 16'h0300 ^ 16'h0454);

    do_cmd(3'd4, 16'd0, 4'd0, 4'd5, 16'd0, "R7");
    wait_idle();

    do_cmd(3'd1, 16'h1234, 4'd3, 4'd0, 16'd0, "R3");
    wait_idle();

    do_cmd(3'd2, 16'd0, 4'd0, 4'd0, 16'd0, "R5");
    wait_idle();
    do_cmd(3'd2, 16'd0, 4'd0, 4'd0, 16'd0, "R5");
    wait_idle();

    do_cmd(3'd1, 16'h4444, 4'd5, 4'd0, 16'd0, "R4");
    wait_idle();

    do_cmd(3'd3, 16'd0, 4'd0, 4'd0, 16'h0777, "R6");
    wait_idle();

    do_cmd(3'd1, 16'h5A5A, 4'd15, 4'd0, 16'd0, "R3");  // top vector slot
    wait_idle();

    // R11: command and PC write during a switch are dropped
    do_cmd(3'd0, 16'h0210, 4'd0, 4'd0, 16'd0, "R11");
    cmd_valid = 1'b1; cmd_op = 3'd3; cmd_imm = 16'h0ABC;
    pc_wr = 1'b1; pc_wdata = 16'h0EEE;
    @(negedge clk);
    cmd_valid = 1'b0; pc_wr = 1'b0;
    wait_idle();
    chk(wp === 16'h0900 && pc === 16'h0A10, "R11", "switch result after injection",
        wp ^ pc, 16'h0900 ^ 16'h0A10);

    do_cmd(3'd2, 16'd0, 4'd0, 4'd0, 16'd0, "R5");
    wait_idle();

    write_pc_st(16'h0C0C, 16'h00FF);           // R12 again after switches
    repeat (3) @(negedge clk);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule